// File: doc/BRIEF.md
# Coax Modem Link Direction Controller

This block sits beside the on-off-keyed coax modem of a mast-top or base node and decides, cycle by cycle, whether the node is idle, receiving from the coax, transmitting onto it, or parked in standby. It runs from the 4x-carrier reference clock. It takes the transmit data bit, the demodulated receive bit (low means carrier present) and a 2-bit rate code. It drives three outputs: a direction signal that enables a local RS-485 driver while coax data is arriving, the final receive data output, and a gated carrier square wave at one quarter of the reference.

The bus direction follows whichever side becomes active first. A retriggerable timeout of about sixteen bit times, chosen by the rate code, holds the mode after the last activity. While the node transmits, the receive output is pinned high so that its own echo is not passed on. The carrier gate opens and closes only on a divider period boundary, so every carrier pulse has its full width.

States: IDLE, RECV, XMIT, STBY. Transitions: IDLE to RECV when the receive bit is low; IDLE to XMIT when the transmit bit is low and the receive bit is high; RECV to IDLE and XMIT to IDLE on timer expiry; any state to STBY on rate code 11; STBY to IDLE on any other code.

Top module: `coax_dir_ctrl`

## Requirements
- R1: After reset the mode is IDLE: dir_out is 0, carrier_out is 0 and rx_data_out is 1 while rx_bit is 1.
- R2: In IDLE, rx_bit low at a clock edge moves the mode to RECV; dir_out is 1 after that edge, and in RECV rx_data_out equals rx_bit.
- R3: In IDLE, tx_bit low with rx_bit high moves the mode to XMIT; in XMIT dir_out is 0 and rx_data_out is 1 whatever rx_bit is.
- R4: When rx_bit and tx_bit go low together in IDLE, the mode becomes RECV.
- R5: RECV is left for IDLE at the N-th clock edge that samples rx_bit high with no low sample in between (N the selected timeout); a low sample of rx_bit restarts the count.
- R6: XMIT is left for IDLE at the N-th clock edge that samples tx_bit high with no low sample in between; a low sample of tx_bit restarts the count.
- R7: N is SLOW_CYC for rate code 00, MID_CYC for 01 and FAST_CYC for 10 (defaults 14510, 3630, 1192 reference cycles).
- R8: A rate code change while the timer is counting does not alter the running count; the new N applies from the next restart.
- R9: In RECV, tx_bit activity does not change the mode; in XMIT, rx_bit activity does not change the mode.
- R10: Rate code 11 moves any mode to STBY at the next edge; in STBY dir_out is 0, carrier_out stays 0 and rx_data_out equals rx_bit; any other code moves STBY to IDLE.
- R11: carrier_out is a square wave of period 4 clock cycles, high for 2, while tx_bit is low and the code is not 11, in RECV and XMIT alike; it is 0 while tx_bit is high.
- R12: The carrier gate changes only at the end of a divider period, so every high pulse of carrier_out lasts exactly 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 4x carrier |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_bit | input | 1 | Transmit data, low sends carrier |
| rx_bit | input | 1 | Demodulated receive data, low means carrier detected |
| rate_code | input | 2 | 00/01/10 select timeout, 11 selects standby |
| dir_out | output | 1 | RS-485 driver enable, high while receiving from coax |
| rx_data_out | output | 1 | Receive data to the logic side |
| carrier_out | output | 1 | Gated carrier square wave |

## Verification
The assertions assume tx_bit, rx_bit and rate_code are already synchronous to the reference clock and change only between edges; the bench drives them on the falling edge so each is sampled cleanly at one rising edge. The hold properties assume the rate code is not 11 in the cycle considered, and the stimulus moves to standby only in its own scenario. Timeouts are overridden to small values in the bench so that every expiry is counted edge by edge.

// File: rtl/coax_dir_pkg.sv
package coax_dir_pkg;

    typedef enum logic [1:0] {
        M_IDLE = 2'd0,
        M_RECV = 2'd1,
        M_XMIT = 2'd2,
        M_STBY = 2'd3
    } mode_e;

    localparam logic [1:0] RATE_SLOW = 2'b00;
    localparam logic [1:0] RATE_MID  = 2'b01;
    localparam logic [1:0] RATE_FAST = 2'b10;
    localparam logic [1:0] RATE_STBY = 2'b11;

endpackage

// File: rtl/coax_dir_timer.sv
module coax_dir_timer #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (reload) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = !reload && (cnt_q == '0);

endmodule

// File: rtl/coax_dir_carrier.sv
module coax_dir_carrier #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic want_on,
    output logic carrier
);

    localparam int PH_W = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(DIV - 1);
    localparam logic [PH_W-1:0] PH_HALF = PH_W'(DIV / 2);

    logic [PH_W-1:0] phase_q;
    logic            gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (phase_q == PH_LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

    // gate only moves when the divider wraps, so pulses are never cut
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
        end else if (phase_q == PH_LAST) begin
            gate_q <= want_on;
        end
    end

    assign carrier = gate_q && (phase_q >= PH_HALF);

endmodule

// File: rtl/coax_dir_ctrl.sv
module coax_dir_ctrl
    import coax_dir_pkg::*;
#(
    parameter int SLOW_CYC = 14510,
    parameter int MID_CYC  = 3630,
    parameter int FAST_CYC = 1192,
    parameter int REF_DIV  = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tx_bit,
    input  logic       rx_bit,
    input  logic [1:0] rate_code,
    output logic       dir_out,
    output logic       rx_data_out,
    output logic       carrier_out
);

    localparam int MAX_CYC = (SLOW_CYC > MID_CYC) ?
                             ((SLOW_CYC > FAST_CYC) ? SLOW_CYC : FAST_CYC) :
                             ((MID_CYC > FAST_CYC) ? MID_CYC : FAST_CYC);
    localparam int CNT_W = $clog2(MAX_CYC + 1);

    mode_e            mode_q;
    mode_e            mode_d;
    logic             tmr_reload;
    logic             tmr_expired;
    logic [CNT_W-1:0] tmr_load;

    // timeout selection from the rate code
    always_comb begin
        unique case (rate_code)
            RATE_MID:  tmr_load = CNT_W'(MID_CYC - 1);
            RATE_FAST: tmr_load = CNT_W'(FAST_CYC - 1);
            default:   tmr_load = CNT_W'(SLOW_CYC - 1);
        endcase
    end

    // activity of the owning side keeps the timer loaded
    always_comb begin
        unique case (mode_q)
            M_RECV:  tmr_reload = !rx_bit;
            M_XMIT:  tmr_reload = !tx_bit;
            default: tmr_reload = 1'b1;
        endcase
    end

    coax_dir_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (tmr_reload),
        .load_val (tmr_load),
        .expired  (tmr_expired)
    );

    // next-state logic
    always_comb begin
        mode_d = mode_q;
        if (rate_code == RATE_STBY) begin
            mode_d = M_STBY;
        end else begin
            unique case (mode_q)
                M_IDLE: begin
                    if (!rx_bit)      mode_d = M_RECV;
                    else if (!tx_bit) mode_d = M_XMIT;
                end
                M_RECV:  if (tmr_expired) mode_d = M_IDLE;
                M_XMIT:  if (tmr_expired) mode_d = M_IDLE;
                M_STBY:  mode_d = M_IDLE;
                default: mode_d = M_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= M_IDLE;
        end else begin
            mode_q <= mode_d;
        end
    end

    // outputs
    always_comb begin
        dir_out     = 1'b0;
        rx_data_out = rx_bit;
        unique case (mode_q)
            M_RECV:  dir_out = 1'b1;
            M_XMIT:  rx_data_out = 1'b1;
            default: ;
        endcase
    end

    coax_dir_carrier #(
        .DIV (REF_DIV)
    ) u_carrier (
        .clk     (clk),
        .rst_n   (rst_n),
        .want_on (!tx_bit && (rate_code != RATE_STBY)),
        .carrier (carrier_out)
    );

endmodule

// File: rtl/coax_dir_ctrl_chk.sv
module coax_dir_ctrl_chk
    import coax_dir_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tx_bit,
    input logic       rx_bit,
    input logic [1:0] rate_code,
    input logic       dir_out,
    input logic       rx_data_out,
    input logic       carrier_out,
    input mode_e      mode_q
);

    AST_IDLE_TO_RECV: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_IDLE && !rx_bit && rate_code != RATE_STBY) |=> dir_out); // R2

    AST_XMIT_RX_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_XMIT) |-> (rx_data_out && !dir_out)); // R3

    AST_SIMUL_RECV: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_IDLE && !rx_bit && !tx_bit && rate_code != RATE_STBY) |=> (mode_q == M_RECV)); // R4

    AST_RECV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_RECV && !rx_bit && rate_code != RATE_STBY) |=> (mode_q == M_RECV)); // R5

    AST_XMIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_XMIT && !tx_bit && rate_code != RATE_STBY) |=> (mode_q == M_XMIT)); // R6

    AST_NO_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == M_RECV) |=> (mode_q != M_XMIT)); // R9

    AST_STBY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_code == RATE_STBY) |=> (mode_q == M_STBY && !dir_out)); // R10

    AST_PULSE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier_out) |=> carrier_out); // R12

    AST_PULSE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(carrier_out) |=> !carrier_out); // R11

endmodule

bind coax_dir_ctrl coax_dir_ctrl_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_bit      (tx_bit),
    .rx_bit      (rx_bit),
    .rate_code   (rate_code),
    .dir_out     (dir_out),
    .rx_data_out (rx_data_out),
    .carrier_out (carrier_out),
    .mode_q      (mode_q)
);

// File: tb/coax_dir_ctrl_tb.sv
module coax_dir_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int SLOW = 40;
    localparam int MID  = 20;
    localparam int FAST = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_bit = 1'b1;
    logic       rx_bit = 1'b1;
    logic [1:0] rate_code = 2'b00;
    logic       dir_out;
    logic       rx_data_out;
    logic       carrier_out;

    int n_cmp = 0;
    int n_bad = 0;
    int run_len = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    coax_dir_ctrl #(
        .SLOW_CYC (SLOW),
        .MID_CYC  (MID),
        .FAST_CYC (FAST)
    ) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_bit      (tx_bit),
        .rx_bit      (rx_bit),
        .rate_code   (rate_code),
        .dir_out     (dir_out),
        .rx_data_out (rx_data_out),
        .carrier_out (carrier_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic waitn(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic settle_idle();
        rx_bit = 1'b1; tx_bit = 1'b1; rate_code = 2'b00;
        waitn(2 * SLOW + 4);
    endtask

    task automatic count_high(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (carrier_out) highs++;
        end
    endtask

    // R12: every high carrier pulse is exactly two cycles wide
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (carrier_out) run_len++;
            else begin
                if (run_len != 0) check("R12 pulse width", run_len, 2);
                run_len = 0;
            end
        end
    end

    task automatic t_reset();
        @(negedge clk); #1;
        check("R1 dir", int'(dir_out), 0);
        check("R1 rx_data_out", int'(rx_data_out), 1);
        check("R1 carrier", int'(carrier_out), 0);
    endtask

    task automatic t_recv_basic();
        rx_bit = 1'b0;
        @(negedge clk); #1;
        check("R2 dir in recv", int'(dir_out), 1);
        check("R2 rx follows", int'(rx_data_out), 0);
        rx_bit = 1'b1; #1;
        check("R2 rx follows high", int'(rx_data_out), 1);
        settle_idle();
    endtask

    task automatic t_xmit_basic();
        int h;
        tx_bit = 1'b0;
        @(negedge clk);
        rx_bit = 1'b0; #1;
        check("R3 rx forced high", int'(rx_data_out), 1);
        check("R3 dir low", int'(dir_out), 0);
        rx_bit = 1'b1;
        waitn(8);
        count_high(8, h);
        check("R11 carrier in xmit", h, 4);
        tx_bit = 1'b1;
        waitn(8);
        count_high(8, h);
        check("R11 carrier off", h, 0);
        settle_idle();
    endtask

    task automatic t_simul();
        rx_bit = 1'b0; tx_bit = 1'b0;
        @(negedge clk); #1;
        check("R4 recv wins dir", int'(dir_out), 1);
        check("R4 rx passes", int'(rx_data_out), 0);
        settle_idle();
    endtask

    task automatic recv_timeout(input logic [1:0] code, input int lim, input string req);
        rate_code = code;
        rx_bit = 1'b0;
        waitn(3);
        rx_bit = 1'b1;
        waitn(lim - 1); #1;
        check({req, " still recv"}, int'(dir_out), 1);
        @(negedge clk); #1;
        check({req, " back to idle"}, int'(dir_out), 0);
        settle_idle();
    endtask

    task automatic t_recv_retrigger();
        rx_bit = 1'b0; waitn(2);
        rx_bit = 1'b1; waitn(SLOW - 5);
        rx_bit = 1'b0; @(negedge clk);
        rx_bit = 1'b1; waitn(SLOW - 1); #1;
        check("R5 retrigger holds", int'(dir_out), 1);
        @(negedge clk); #1;
        check("R5 expiry after retrigger", int'(dir_out), 0);
        settle_idle();
    endtask

    task automatic t_xmit_timeout();
        tx_bit = 1'b0; waitn(3);
        tx_bit = 1'b1; waitn(SLOW - 1);
        rx_bit = 1'b0; #1;
        check("R6 still xmit", int'(rx_data_out), 1);
        @(negedge clk); #1;
        check("R6 left xmit", int'(rx_data_out), 0);
        settle_idle();
    endtask

    task automatic t_rate_change();
        rate_code = 2'b00;
        rx_bit = 1'b0; waitn(2);
        rx_bit = 1'b1; rate_code = 2'b10;
        waitn(SLOW - 1); #1;
        check("R8 running count kept", int'(dir_out), 1);
        @(negedge clk); #1;
        check("R8 old timeout ends", int'(dir_out), 0);
        rx_bit = 1'b0; waitn(2);
        rx_bit = 1'b1; waitn(FAST - 1); #1;
        check("R8 new timeout holds", int'(dir_out), 1);
        @(negedge clk); #1;
        check("R8 new timeout ends", int'(dir_out), 0);
        settle_idle();
    endtask

    task automatic t_exclusive();
        int h;
        rx_bit = 1'b0; waitn(2);
        rx_bit = 1'b1; tx_bit = 1'b0;
        waitn(8);
        #1 check("R9 tx in recv keeps dir", int'(dir_out), 1);
        count_high(8, h);
        check("R11 carrier in recv", h, 4);
        tx_bit = 1'b1;
        settle_idle();
        tx_bit = 1'b0; waitn(2);
        rx_bit = 1'b0; waitn(4); #1;
        check("R9 rx in xmit keeps dir low", int'(dir_out), 0);
        check("R9 rx in xmit forced high", int'(rx_data_out), 1);
        settle_idle();
    endtask

    task automatic t_standby();
        int h;
        tx_bit = 1'b0; waitn(2);
        rate_code = 2'b11;
        @(negedge clk);
        rx_bit = 1'b0; #1;
        check("R10 rx follows in standby", int'(rx_data_out), 0);
        check("R10 dir low", int'(dir_out), 0);
        waitn(8);
        count_high(8, h);
        check("R10 carrier silent", h, 0);
        tx_bit = 1'b1;
        rate_code = 2'b00;
        waitn(2); #1;
        check("R10 leave standby then recv", int'(dir_out), 1);
        settle_idle();
    endtask

    initial begin
        waitn(3);
        rst_n = 1'b1;
        t_reset();
        t_recv_basic();
        t_xmit_basic();
        t_simul();
        recv_timeout(2'b00, SLOW, "R7 code00 R5");
        recv_timeout(2'b01, MID,  "R7 code01");
        recv_timeout(2'b10, FAST, "R7 code10");
        t_recv_retrigger();
        t_xmit_timeout();
        t_rate_change();
        t_exclusive();
        t_standby();
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        done = 1'b1;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule